// File: doc/BRIEF.md
# Fetch Stall Misprediction Controller

This block gates the fetch stage of an in-order pipeline that never lets wrong-path instructions in. When fetch issues a conditional branch, the controller compares the predictor's guess with the branch's recorded true outcome, which is already known at fetch. If the two agree, fetch carries on with no bubble. If they disagree, the controller drops the fetch enable and holds it low. It stays low until the execute stage signals that the branch has resolved and supplies the correct target.

In the cycle after the resolve pulse, the controller writes the target into the PC latch. In the cycle after that, it raises fetch enable again so that fetch continues down the correct path. A configuration input turns the predictor off. With the predictor off, every conditional branch stalls fetch until it resolves. Branch kinds other than conditional never stall.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: After reset, `fetch_en_o` is 1 and `pc_wr_o` is 0.
- R2: A valid fetch whose `fe_kind_i` is not the conditional code (conditional is 2'b01; 2'b00, 2'b10 and 2'b11 are other kinds) leaves `fetch_en_o` at 1 in the next cycle.
- R3: With `pred_en_i`=1, an issued conditional branch whose `pred_taken_i` equals `actual_taken_i` leaves `fetch_en_o` at 1 in the next cycle.
- R4: With `pred_en_i`=1, an issued conditional branch whose prediction differs from its outcome drives `fetch_en_o` to 0 from the next cycle. It stays 0 until a resolve pulse arrives.
- R5: With `pred_en_i`=0, every issued conditional branch stalls fetch in the same way as a mismatch, whatever the prediction.
- R6: A resolve pulse during a stall makes `pc_wr_o` 1 for exactly one cycle in the next cycle. In that cycle `pc_wr_data_o` equals the `ex_target_i` sampled with the pulse.
- R7: `fetch_en_o` is 0 in the cycle `pc_wr_o` is 1, and returns to 1 in the cycle after.
- R8: A resolve pulse while no stall is pending has no effect: `pc_wr_o` stays 0 and `fetch_en_o` stays 1.
- R9: Fetch inputs presented while fetch is stalled are ignored. A second mismatched branch offered during the stall does not extend it past the resolve sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_en_i | input | 1 | 1: use the predictor; 0: stall on every conditional branch |
| fe_valid_i | input | 1 | Fetch stage offers an instruction this cycle |
| fe_kind_i | input | KIND_W | Branch kind of the offered instruction (2'b01 = conditional) |
| pred_taken_i | input | 1 | Predicted direction |
| actual_taken_i | input | 1 | Recorded true direction |
| ex_resolve_i | input | 1 | Execute stage resolves the stalled branch (one-cycle pulse) |
| ex_target_i | input | PC_W | Correct-path PC supplied with the resolve pulse |
| pc_wr_o | output | 1 | Write enable for the PC latch |
| pc_wr_data_o | output | PC_W | Value written into the PC latch |
| fetch_en_o | output | 1 | Fetch may issue an instruction this cycle |

## Verification
The bench uses the default parameters: a 32-bit PC and 2-bit branch kinds with conditional coded as 2'b01. With these values all four kind codes can be driven, so each non-conditional kind can be shown to pass with no bubble. A full-width target can be used to tell the reloaded PC apart from stale values. Stalls are held for several cycles before resolve to show that the hold does not depend on timing. Stray resolves and branches offered during a stall are also driven.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    FS_RUN  = 2'd0,
    FS_WAIT = 2'd1,
    FS_LOAD = 2'd2
  } fs_state_e;

  // Stall is needed for a conditional branch when the predictor is off or wrong.
  function automatic logic fs_needs_stall(input logic is_cond, input logic pred_en,
                                          input logic pred, input logic actual);
    return is_cond & (~pred_en | (pred ^ actual));
  endfunction
endpackage

// File: rtl/fs_branch_classify.sv
module fs_branch_classify #(
  parameter int KIND_W    = 2,
  parameter int COND_CODE = 1
) (
  input  logic              issue_ok,
  input  logic              valid,
  input  logic [KIND_W-1:0] kind,
  input  logic              pred_en,
  input  logic              pred,
  input  logic              actual,
  output logic              stall_evt
);
  import fs_pkg::*;
  localparam logic [KIND_W-1:0] COND_K = KIND_W'(COND_CODE);

  logic is_cond;
  assign is_cond   = (kind == COND_K);
  assign stall_evt = issue_ok & valid & fs_needs_stall(is_cond, pred_en, pred, actual);

  // R2: a non-conditional kind never requests a stall
  always_comb a_r2_noncond_no_stall: assert (!(valid && !is_cond && stall_evt));
endmodule

// File: rtl/fs_stall_fsm.sv
module fs_stall_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_evt,
  input  logic resolve,
  output logic fetch_en,
  output logic reload,
  output logic waiting
);
  import fs_pkg::*;
  fs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_RUN:  if (stall_evt) state_d = FS_WAIT;
      FS_WAIT: if (resolve)   state_d = FS_LOAD;
      FS_LOAD: state_d = FS_RUN;
      default: state_d = FS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FS_RUN;
    else        state_q <= state_d;
  end

  assign fetch_en = (state_q == FS_RUN);
  assign reload   = (state_q == FS_LOAD);
  assign waiting  = (state_q == FS_WAIT);

  // R4: a stall request holds fetch off in the following cycle
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> !fetch_en);
  // R4: waiting persists until resolve
  a_r4_wait_until_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !resolve) |=> waiting);
  // R7: reload is a single cycle followed by fetch
  a_r7_reload_then_run: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (fetch_en && !reload));
endmodule

// File: rtl/fs_pc_reload.sv
module fs_pc_reload #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (capture) pc_q <= target;
  end

  // R6: the held PC is the target taken with the capture
  a_r6_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (pc_q == $past(target)));
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl #(
  parameter int PC_W      = 32,
  parameter int KIND_W    = 2,
  parameter int COND_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_en_i,
  input  logic              fe_valid_i,
  input  logic [KIND_W-1:0] fe_kind_i,
  input  logic              pred_taken_i,
  input  logic              actual_taken_i,
  input  logic              ex_resolve_i,
  input  logic [PC_W-1:0]   ex_target_i,
  output logic              pc_wr_o,
  output logic [PC_W-1:0]   pc_wr_data_o,
  output logic              fetch_en_o
);
  logic stall_evt, fetch_en, reload, waiting, capture;

  fs_branch_classify #(.KIND_W(KIND_W), .COND_CODE(COND_CODE)) u_classify (
    .issue_ok (fetch_en),
    .valid    (fe_valid_i),
    .kind     (fe_kind_i),
    .pred_en  (pred_en_i),
    .pred     (pred_taken_i),
    .actual   (actual_taken_i),
    .stall_evt(stall_evt)
  );

  fs_stall_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_evt(stall_evt),
    .resolve  (ex_resolve_i),
    .fetch_en (fetch_en),
    .reload   (reload),
    .waiting  (waiting)
  );

  assign capture = waiting & ex_resolve_i;

  fs_pc_reload #(.PC_W(PC_W)) u_reload (
    .clk   (clk),
    .rst_n (rst_n),
    .capture(capture),
    .target(ex_target_i),
    .pc_q  (pc_wr_data_o)
  );

  assign pc_wr_o    = reload;
  assign fetch_en_o = fetch_en;

  // R6: resolve during a stall writes the PC next cycle
  a_r6_resolve_writes: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> pc_wr_o);
  // R7: no issue while the PC is being written
  a_r7_no_issue_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_o |-> !fetch_en_o);
  // R8: resolve while running changes nothing
  a_r8_stray_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o && ex_resolve_i && !stall_evt) |=> (fetch_en_o && !pc_wr_o));
  // R3: a correctly predicted conditional branch keeps fetch running
  a_r3_hit_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o && fe_valid_i && pred_en_i && (pred_taken_i == actual_taken_i))
      |=> fetch_en_o);
endmodule

// File: tb/fetch_stall_ctrl_bench.sv
module fetch_stall_ctrl_bench;
  localparam int PC_W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_en, fe_valid, pred_t, act_t, resolve;
  logic [1:0] kind;
  logic [PC_W-1:0] target;
  logic pc_wr, fetch_en;
  logic [PC_W-1:0] pc_data;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fetch_stall_ctrl u_fetch_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .pred_en_i(pred_en), .fe_valid_i(fe_valid),
    .fe_kind_i(kind), .pred_taken_i(pred_t), .actual_taken_i(act_t),
    .ex_resolve_i(resolve), .ex_target_i(target), .pc_wr_o(pc_wr),
    .pc_wr_data_o(pc_data), .fetch_en_o(fetch_en)
  );

  task automatic check(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fe_valid = 0; kind = 2'b00; pred_t = 0; act_t = 0; resolve = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 fetch_en", {31'd0, fetch_en}, 1);
    check("R1 pc_wr", {31'd0, pc_wr}, 0);
  endtask

  task automatic t_noncond();
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      fe_valid = 1; kind = 2'(k); pred_t = 1; act_t = 0;
      step();
      check("R2 no bubble", {31'd0, fetch_en}, 1);
    end
    idle();
    step();
  endtask

  task automatic t_stray_resolve();
    resolve = 1; target = 32'hDEAD_0000;
    step();
    idle();
    check("R8 fetch_en", {31'd0, fetch_en}, 1);
    check("R8 pc_wr", {31'd0, pc_wr}, 0);
    step();
    check("R8 pc_wr later", {31'd0, pc_wr}, 0);
  endtask

  task automatic t_hit();
    pred_en = 1;
    for (int v = 0; v < 2; v++) begin
      fe_valid = 1; kind = 2'b01; pred_t = v[0]; act_t = v[0];
      step();
      check("R3 hit no bubble", {31'd0, fetch_en}, 1);
    end
    idle();
    step();
  endtask

  // Issue a stalling branch, wait, resolve; optionally offer branches while stalled.
  task automatic stall_cycle(input string req, input logic [PC_W-1:0] tgt, input bit poke);
    fe_valid = 1; kind = 2'b01;
    step();
    if (!poke) idle();
    for (int i = 0; i < 3; i++) begin
      check({req, " stalled"}, {31'd0, fetch_en}, 0);
      check({req, " no write"}, {31'd0, pc_wr}, 0);
      if (poke) begin fe_valid = 1; kind = 2'b01; pred_t = ~act_t; end
      step();
    end
    idle();
    resolve = 1; target = tgt;
    step();
    idle();
    target = ~tgt;
    check("R6 pc_wr", {31'd0, pc_wr}, 1);
    check("R6 pc data", pc_data, tgt);
    check("R7 no fetch on write", {31'd0, fetch_en}, 0);
    if (poke) begin fe_valid = 1; kind = 2'b00; end
    step();
    check("R7 fetch resumes", {31'd0, fetch_en}, 1);
    check("R6 single write", {31'd0, pc_wr}, 0);
    idle();
    step();
    check({req, " stays running"}, {31'd0, fetch_en}, 1);
  endtask

  task automatic t_mispredict();
    pred_en = 1; pred_t = 1; act_t = 0;
    stall_cycle("R4", 32'h1234_5678, 0);
  endtask

  task automatic t_disabled();
    pred_en = 0; pred_t = 1; act_t = 1;
    stall_cycle("R5", 32'hA5A5_0F0F, 0);
    pred_en = 1;
  endtask

  task automatic t_ignore_stalled();
    pred_en = 1; pred_t = 0; act_t = 1;
    stall_cycle("R9", 32'h0000_BEEF, 1);
  endtask

  initial begin
    pred_en = 1; target = '0;
    idle();
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_noncond();
    t_stray_resolve();
    t_hit();
    t_mispredict();
    t_disabled();
    t_ignore_stalled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule